// File: doc/BRIEF.md
# Four-Mode Port Pin Driver Controller

This block turns the output latch of a general-purpose I/O port into separate pull-up and pull-down driver enables, one pair per pin. Two configuration registers, one bit per pin in each, choose how each pin drives: quasi-bidirectional, push-pull, high impedance or open drain. Every pin is configured independently of the others. The block also returns a synchronised copy of the pad input for read-back.

In quasi-bidirectional mode a low latch pulls the pin down. When the latch rises, the pin is driven high strongly for exactly one clock. After that the pull-up is released and the pin behaves as open drain, which relies on an external resistor. This sharpens rising edges without a permanent high-side drive. Quasi-bidirectional is the mode of every pin out of reset.

Both configuration registers load together on a single write strobe. The pad drivers, voltage levels and external resistors lie outside the block.

Top module: `pin_drive_ctl`

## Requirements
- R1: While reset is asserted and right after it, every pin is quasi-bidirectional, `pu_en` is all zero, `pd_en` equals the inverse of `out_latch`, and `rd_val` is all zero.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_a` and `cfg_b` are loaded. The mode of pin i is {`cfg_b`[i], `cfg_a`[i]}: 00 quasi-bidirectional, 01 push-pull, 10 high impedance, 11 open drain.
- R3: In quasi-bidirectional mode, a 0-to-1 change of a latch bit makes that pin's `pu_en` high for exactly one cycle. The pulse starts after the first clock edge that samples the new 1. In this mode `pd_en` is the inverse of the latch.
- R4: A quasi-bidirectional pin whose latch stays high has no pull-up. No pull-up pulse follows reset release when the latch is already high.
- R5: In push-pull mode `pu_en` equals the latch and `pd_en` equals its inverse.
- R6: In high-impedance mode both enables are low whatever the latch holds.
- R7: In open-drain mode `pu_en` is always low and `pd_en` is the inverse of the latch.
- R8: `pu_en` and `pd_en` are never high together on the same pin.
- R9: The mode in force after an edge decides whether a rise seen at that edge starts a pulse. Entering quasi-bidirectional at that edge starts one. Leaving quasi-bidirectional during a pulse ends it at once, and returning to quasi-bidirectional with the latch still high gives no new pulse.
- R10: `rd_val` equals `pad_in` as it stood two rising clock edges earlier.
- R11: Each pin follows its own mode; pins in different modes on the same port do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for both configuration registers |
| cfg_a | input | W | Configuration register A write data |
| cfg_b | input | W | Configuration register B write data |
| out_latch | input | W | Port output latch |
| pad_in | input | W | Pad input sample |
| pu_en | output | W | Pull-up driver enable per pin |
| pd_en | output | W | Pull-down driver enable per pin |
| rd_val | output | W | Synchronised pad value for read-back |

## Verification
Each mode is driven with complementary latch patterns such as 0x96/0x69 and 0xAA/0x55. A stuck bit or a swapped enable therefore shows on some pin.

The quasi-bidirectional pulse is tried with three patterns:
- a multi-bit rise followed by held-high cycles, which separates a one-cycle pulse from a level or a two-cycle pulse;
- a rise while the mode is being left, a mode write while a pulse is running, and a rise at the same edge that quasi-bidirectional is entered, which together show whether the pulse is gated by the old mode or the new one;
- a port split into four mode pairs, which shows that pins do not interact.

Distinct pad values two edges apart show the exact read-back latency.

// File: rtl/pin_drive_ctl.sv
module pin_drive_ctl #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_a,
  input  logic [W-1:0] cfg_b,
  input  logic [W-1:0] out_latch,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pu_en,
  output logic [W-1:0] pd_en,
  output logic [W-1:0] rd_val
);

  logic [W-1:0] cfg_a_q, cfg_b_q;
  logic [W-1:0] latch_d, boost;
  logic [W-1:0] nxt_a, nxt_b, nxt_quasi, rise;
  logic [SYNC-1:0][W-1:0] sync_q;

  assign nxt_a     = cfg_we ? cfg_a : cfg_a_q;
  assign nxt_b     = cfg_we ? cfg_b : cfg_b_q;
  assign nxt_quasi = ~nxt_a & ~nxt_b;
  assign rise      = out_latch & ~latch_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_a_q <= '0;
      cfg_b_q <= '0;
      latch_d <= '1;
      boost   <= '0;
    end else begin
      cfg_a_q <= nxt_a;
      cfg_b_q <= nxt_b;
      latch_d <= out_latch;
      boost   <= rise & nxt_quasi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q[0] <= pad_in;
      for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
    end
  end

  assign rd_val = sync_q[SYNC-1];

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      unique case ({cfg_b_q[i], cfg_a_q[i]})
        2'b00: begin pu_en[i] = boost[i] & out_latch[i]; pd_en[i] = ~out_latch[i]; end
        2'b01: begin pu_en[i] = out_latch[i];            pd_en[i] = ~out_latch[i]; end
        2'b10: begin pu_en[i] = 1'b0;                    pd_en[i] = 1'b0;          end
        default: begin pu_en[i] = 1'b0;                  pd_en[i] = ~out_latch[i]; end
      endcase
    end
  end

endmodule

// File: rtl/pin_drive_ctl_chk.sv
module pin_drive_ctl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cfg_a_q,
  input logic [W-1:0] cfg_b_q,
  input logic [W-1:0] out_latch,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pu_en,
  input logic [W-1:0] pd_en,
  input logic [W-1:0] rd_val
);

  logic [W-1:0] m_q, m_pp, m_hz, m_od;
  logic [1:0] age;

  assign m_q  = ~cfg_b_q & ~cfg_a_q;
  assign m_pp = ~cfg_b_q &  cfg_a_q;
  assign m_hz =  cfg_b_q & ~cfg_a_q;
  assign m_od =  cfg_b_q &  cfg_a_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_no_fight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & pd_en) == '0);

  p_hiz_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_en | pd_en) & m_hz) == '0);

  p_od_no_pull_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & m_od) == '0);

  p_pp_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_en & m_pp) == (out_latch & m_pp)) && ((pd_en & m_pp) == (~out_latch & m_pp)));

  p_pulse_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_en & m_q) != '0) |=> ((pu_en & m_q & $past(pu_en & m_q)) == '0));

  p_quasi_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_en & m_q) == (~out_latch & m_q));

  p_sync_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2) |-> (rd_val == $past(pad_in, 2)));

endmodule

bind pin_drive_ctl pin_drive_ctl_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_a_q   (cfg_a_q),
  .cfg_b_q   (cfg_b_q),
  .out_latch (out_latch),
  .pad_in    (pad_in),
  .pu_en     (pu_en),
  .pd_en     (pd_en),
  .rd_val    (rd_val)
);

// File: tb/pin_drive_ctl_bench.sv
`timescale 1ns/1ps
module pin_drive_ctl_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [W-1:0] cfg_a = '0, cfg_b = '0, out_latch = '0, pad_in = '0;
  logic [W-1:0] pu_en, pd_en, rd_val;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pin_drive_ctl #(.W(W), .SYNC(2)) u_pin_drive_ctl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_a(cfg_a), .cfg_b(cfg_b),
    .out_latch(out_latch), .pad_in(pad_in), .pu_en(pu_en), .pd_en(pd_en),
    .rd_val(rd_val));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_drv(input string req, input logic [W-1:0] pu, input logic [W-1:0] pd);
    chk(req, "pu_en", pu_en, pu);
    chk(req, "pd_en", pd_en, pd);
  endtask

  task automatic write_cfg(input logic [W-1:0] a, input logic [W-1:0] b);
    cfg_we = 1'b1; cfg_a = a; cfg_b = b;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    out_latch = 8'hF0; pad_in = 8'hFF;
    tick(); tick();
    chk_drv("R1", 8'h00, 8'h0F);
    chk("R1", "rd_val", rd_val, 8'h00);
    rst_n = 1'b1;
    tick();
    chk_drv("R4", 8'h00, 8'h0F);
    tick();
    chk_drv("R4", 8'h00, 8'h0F);
  endtask

  task automatic t_quasi();
    write_cfg(8'h00, 8'h00);
    out_latch = 8'h00; tick();
    chk_drv("R3", 8'h00, 8'hFF);
    out_latch = 8'h3C; tick();
    chk_drv("R3", 8'h3C, 8'hC3);
    tick();
    chk_drv("R3", 8'h00, 8'hC3);
    tick();
    chk_drv("R4", 8'h00, 8'hC3);
    out_latch = 8'h00; tick();
    out_latch = 8'h01; tick();
    chk_drv("R3", 8'h01, 8'hFE);
    out_latch = 8'h00; tick();
    chk_drv("R3", 8'h00, 8'hFF);
  endtask

  task automatic t_push_pull();
    write_cfg(8'hFF, 8'h00);
    out_latch = 8'h96; tick();
    chk_drv("R5", 8'h96, 8'h69);
    out_latch = 8'h69; tick();
    chk_drv("R5", 8'h69, 8'h96);
  endtask

  task automatic t_hiz();
    write_cfg(8'h00, 8'hFF);
    out_latch = 8'hAA; tick();
    chk_drv("R6", 8'h00, 8'h00);
    out_latch = 8'h55; tick();
    chk_drv("R6", 8'h00, 8'h00);
  endtask

  task automatic t_open_drain();
    write_cfg(8'hFF, 8'hFF);
    out_latch = 8'h0F; tick();
    chk_drv("R7", 8'h00, 8'hF0);
    out_latch = 8'hFF; tick();
    chk_drv("R7", 8'h00, 8'h00);
    tick();
    chk_drv("R7", 8'h00, 8'h00);
  endtask

  task automatic t_mixed();
    out_latch = 8'h00;
    write_cfg(8'hCC, 8'hF0);
    tick();
    chk_drv("R11", 8'h00, 8'hCF);
    out_latch = 8'hFF; tick();
    chk_drv("R11", 8'h0F, 8'h00);
    tick();
    chk_drv("R11", 8'h0C, 8'h00);
    out_latch = 8'h00; tick();
    chk_drv("R11", 8'h00, 8'hCF);
  endtask

  task automatic t_mode_edge();
    write_cfg(8'h00, 8'h00);
    out_latch = 8'h00; tick();
    out_latch = 8'hFF; tick();
    chk_drv("R9", 8'hFF, 8'h00);
    write_cfg(8'hFF, 8'hFF);
    chk_drv("R9", 8'h00, 8'h00);
    write_cfg(8'h00, 8'h00);
    chk_drv("R9", 8'h00, 8'h00);
    write_cfg(8'hFF, 8'h00);
    out_latch = 8'h00; tick();
    out_latch = 8'hFF;
    write_cfg(8'h00, 8'h00);
    chk_drv("R9", 8'hFF, 8'h00);
    tick();
    chk_drv("R9", 8'h00, 8'h00);
    out_latch = 8'h00; tick();
    out_latch = 8'hFF;
    write_cfg(8'hFF, 8'hFF);
    write_cfg(8'hFF, 8'h00);
    chk_drv("R2", 8'hFF, 8'h00);
  endtask

  task automatic t_sync();
    pad_in = 8'h00; tick(); tick(); tick();
    pad_in = 8'h5A; tick();
    chk("R10", "rd_val", rd_val, 8'h00);
    pad_in = 8'hA5; tick();
    chk("R10", "rd_val", rd_val, 8'h5A);
    tick();
    chk("R10", "rd_val", rd_val, 8'hA5);
  endtask

  initial begin
    #1;
    t_reset();
    t_quasi();
    t_push_pull();
    t_hiz();
    t_open_drain();
    t_mixed();
    t_mode_edge();
    t_sync();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule